// File: doc/BRIEF.md
# Multi-Rate Quasi-Cyclic LDPC Encoder

This block is a systematic encoder for quasi-cyclic low-density parity-check codes. Information bits arrive one per transfer on a valid/ready input. Parity is formed on the fly by multiplying each bit with a generator built from circulant blocks. The code rate comes from a two-bit select input and is one of three rates (0.4, 0.6 and 0.8). With the defaults, every codeword has five blocks of eight bits, and 2, 3 or 4 of those blocks carry information.

The design has four parts. An input store keeps one small memory per information block. A generator store holds, in one bank per parity unit, only the first row of each circulant. The shift-and-accumulate units all work on the same bit at once. A two-half output store lets one codeword be read out while the next is being encoded. The output is a bit stream with valid, ready and an end-of-codeword marker.

Top module: `qc_ldpc_enc`

## Requirements
- R1: After a synchronous reset, out_valid is 0 and in_ready is 1.
- R2: rate_sel 0, 1 and 2 select 2, 3 and 4 information blocks, and rate_sel 3 behaves exactly like 0. A codeword is always NBLK*Z bits long: the information blocks come first, then the parity blocks.
- R3: Output codeword bits 0 to k*Z-1 equal the information bits in the order they were accepted.
- R4: Parity block p, bit c (codeword bit (k+p)*Z+c), is the XOR over all information bits u[i*Z+r] that are 1 of g(m,i,p)[(c-r) mod Z].
  - m is the effective rate index.
  - g(m,i,p) is the low Z bits of h = x ^ (x >> 15), where x = (16m+4i+p+1) * 0x9E3779B1 taken modulo 2^32.
- R5: The rate is taken from rate_sel on the first accepted bit of a codeword. Changes to rate_sel later in the same codeword have no effect.
- R6: Two complete codewords can be held while the output is stalled. in_ready stays 0 while both are held, and it returns to 1 once they have been read out.
- R7: Output bits leave in codeword index order. While out_valid is 1 and out_ready is 0, out_bit and out_last hold their values. out_last is 1 only on codeword bit NBLK*Z-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 2 | Code rate select, sampled on the first bit of a codeword |
| in_valid | input | 1 | Information bit valid |
| in_bit | input | 1 | Information bit |
| in_ready | output | 1 | Encoder can accept a bit |
| out_valid | output | 1 | Codeword bit valid |
| out_bit | output | 1 | Codeword bit |
| out_last | output | 1 | Final bit of the codeword |
| out_ready | input | 1 | Downstream accepts the codeword bit |

## Verification
Random messages are run at every rate, including select value 3, and each one is compared against a full GF(2) product with the expanded generator. Messages with a single 1 pick out one circulant row at a time, so they expose any error in the rotation direction or the reload point. All-ones and all-zero messages test the XOR accumulation and the clearing of the accumulators between codewords. Changing the rate in the middle of a codeword, combined with output stalls and a run with the output fully blocked, tests when the rate is sampled, the double buffering and the handshake hold.

// File: rtl/qc_enc_pkg.sv
package qc_enc_pkg;
  // First row of circulant (rate m, info block i, parity block p).
  function automatic logic [31:0] qc_gvec(input int m, input int i, input int p);
    logic [31:0] x;
    x = 32'(16 * m + 4 * i + p + 1) * 32'h9E3779B1;
    return x ^ (x >> 15);
  endfunction
endpackage

// File: rtl/qc_in_store.sv
module qc_in_store #(
  parameter int Z    = 8,
  parameter int KMAX = 4,
  parameter int NBLK = 5
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic [$clog2(KMAX+1)-1:0]  wblk,
  input  logic [$clog2(Z)-1:0]       wpos,
  input  logic                       wbit,
  input  logic [$clog2(NBLK+1)-1:0]  rblk,
  output logic [Z-1:0]               rword
);
  logic [Z-1:0] bank [KMAX];

  // One small memory per information block.
  for (genvar b = 0; b < KMAX; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (we && int'(wblk) == b) bank[b][wpos] <= wbit;
    end
  end

  always_comb begin
    rword = '0;
    for (int b = 0; b < KMAX; b++)
      if (int'(rblk) == b) rword = bank[b];
  end
endmodule

// File: rtl/qc_gen_bank.sv
module qc_gen_bank #(
  parameter int Z     = 8,
  parameter int KMAX  = 4,
  parameter int NRATE = 3,
  parameter int BANK  = 0,
  localparam int NROM = NRATE * KMAX,
  localparam int RW   = $clog2(NROM)
) (
  input  logic [RW-1:0] addr,
  output logic [Z-1:0]  vec
);
  import qc_enc_pkg::*;
  logic [Z-1:0] rom [NROM];

  initial begin
    for (int a = 0; a < NROM; a++) begin
      logic [31:0] v;
      v = qc_gvec(a / KMAX, a % KMAX, BANK);
      rom[a] = v[Z-1:0];
    end
  end

  assign vec = rom[addr];
endmodule

// File: rtl/qc_mac_unit.sv
module qc_mac_unit #(
  parameter int Z = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         load,
  input  logic         clr,
  input  logic         din,
  input  logic [Z-1:0] gvec,
  output logic [Z-1:0] acc
);
  logic [Z-1:0] sr;
  logic [Z-1:0] tap;
  logic [Z-1:0] term;

  always_comb begin
    tap  = load ? gvec : sr;
    term = tap & {Z{din}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr  <= '0;
      acc <= '0;
    end else if (en) begin
      acc <= clr ? term : (acc ^ term);
      sr  <= {tap[Z-2:0], tap[Z-1]};
    end
  end

  // R4: rotation keeps the row weight of the circulant
  assert_rot_weight_R4: assert property (@(posedge clk) disable iff (rst)
    (en && !load) |=> ($countones(sr) == $past($countones(sr))));
endmodule

// File: rtl/qc_out_store.sv
module qc_out_store #(
  parameter int Z    = 8,
  parameter int NBLK = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [$clog2(NBLK+1)-1:0]  wr_blk,
  input  logic [Z-1:0]               wr_data,
  input  logic                       wr_commit,
  output logic                       wr_free,
  input  logic                       out_ready,
  output logic                       out_valid,
  output logic                       out_bit,
  output logic                       out_last
);
  localparam int DEPTH = 2 * NBLK;
  localparam int AW    = $clog2(DEPTH);
  localparam int ZW    = $clog2(Z);
  localparam int BW    = $clog2(NBLK+1);

  typedef enum logic [1:0] {R_IDLE, R_W1, R_W2, R_OUT} rd_state_t;

  logic [Z-1:0]  mem [DEPTH];
  logic [Z-1:0]  rd_data;
  logic [AW-1:0] rd_addr;
  logic [AW-1:0] wr_addr;
  logic [1:0]    full;
  logic          wr_half, rd_half;
  rd_state_t     rstate;
  logic [Z-1:0]  sh;
  logic [ZW-1:0] ccnt;
  logic [BW-1:0] bcnt;
  logic          rd_done;

  assign wr_addr = AW'(int'(wr_half) * NBLK + int'(wr_blk));
  assign wr_free = !full[wr_half];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

  assign rd_done = (rstate == R_OUT) && out_ready && (int'(ccnt) == Z - 1)
                   && (int'(bcnt) == NBLK - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      full    <= '0;
      wr_half <= 1'b0;
    end else begin
      if (wr_commit) begin
        full[wr_half] <= 1'b1;
        wr_half       <= ~wr_half;
      end
      if (rd_done) full[rd_half] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rstate  <= R_IDLE;
      rd_half <= 1'b0;
      rd_addr <= '0;
      sh      <= '0;
      ccnt    <= '0;
      bcnt    <= '0;
    end else begin
      case (rstate)
        R_IDLE: if (full[rd_half]) begin
          rd_addr <= AW'(int'(rd_half) * NBLK);
          rstate  <= R_W1;
        end
        R_W1: rstate <= R_W2;
        R_W2: begin
          sh      <= rd_data;
          rd_addr <= rd_addr + 1'b1;
          ccnt    <= '0;
          bcnt    <= '0;
          rstate  <= R_OUT;
        end
        default: if (out_ready) begin
          if (int'(ccnt) == Z - 1) begin
            ccnt <= '0;
            if (int'(bcnt) == NBLK - 1) begin
              rd_half <= ~rd_half;
              rstate  <= R_IDLE;
            end else begin
              sh   <= rd_data;
              bcnt <= bcnt + 1'b1;
              if (int'(bcnt) < NBLK - 2) rd_addr <= rd_addr + 1'b1;
            end
          end else begin
            sh   <= sh >> 1;
            ccnt <= ccnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign out_valid = (rstate == R_OUT);
  assign out_bit   = sh[0];
  assign out_last  = out_valid && (int'(ccnt) == Z - 1) && (int'(bcnt) == NBLK - 1);

  // R6: the writer never lands in a half that still holds a codeword
  assert_no_overwrite_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full[wr_half]);

  // R7: stalled output holds its bit and marker
  assert_hold_stall_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(out_last)));
endmodule

// File: rtl/qc_ldpc_enc.sv
module qc_ldpc_enc #(
  parameter int Z    = 8,
  parameter int NBLK = 5,
  parameter int KR0  = 2,
  parameter int KR1  = 3,
  parameter int KR2  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rate_sel,
  input  logic       in_valid,
  input  logic       in_bit,
  output logic       in_ready,
  output logic       out_valid,
  output logic       out_bit,
  output logic       out_last,
  input  logic       out_ready
);
  localparam int KMAX  = KR2;
  localparam int NPU   = NBLK - KR0;
  localparam int NRATE = 3;
  localparam int RW    = $clog2(NRATE * KMAX);
  localparam int ZW    = $clog2(Z);
  localparam int KW    = $clog2(KMAX + 1);
  localparam int BW    = $clog2(NBLK + 1);

  typedef enum logic {S_ENC, S_COPY} enc_state_t;

  function automatic logic [KW-1:0] kval(input logic [1:0] m);
    case (m)
      2'd0:    return KW'(KR0);
      2'd1:    return KW'(KR1);
      default: return KW'(KR2);
    endcase
  endfunction

  enc_state_t    state;
  logic [ZW-1:0] pos_cnt;
  logic [KW-1:0] blk_cnt;
  logic [1:0]    cur_m;
  logic [BW-1:0] cp_cnt;
  logic [15:0]   tally;

  logic          first, accept, last_bit;
  logic [1:0]    m_sel, m_eff;
  logic [KW-1:0] k_eff;
  logic [RW-1:0] rom_addr;
  logic          wr_en, wr_commit, wr_free;
  logic [Z-1:0]  in_word, cw_word;
  logic [Z-1:0]  acc     [NPU];
  logic [Z-1:0]  rom_vec [NPU];

  assign first    = (pos_cnt == '0) && (blk_cnt == '0);
  assign m_sel    = (rate_sel == 2'd3) ? 2'd0 : rate_sel;
  assign m_eff    = first ? m_sel : cur_m;
  assign k_eff    = kval(m_eff);
  assign in_ready = (state == S_ENC) && wr_free;
  assign accept   = in_valid && in_ready;
  assign last_bit = (int'(pos_cnt) == Z - 1) && (int'(blk_cnt) == int'(k_eff) - 1);
  assign rom_addr = RW'(int'(m_eff) * KMAX + int'(blk_cnt));
  assign wr_en    = (state == S_COPY);
  assign wr_commit = wr_en && (int'(cp_cnt) == NBLK - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_ENC;
      pos_cnt <= '0;
      blk_cnt <= '0;
      cur_m   <= '0;
      cp_cnt  <= '0;
    end else if (state == S_ENC) begin
      if (accept) begin
        if (first) cur_m <= m_sel;
        if (int'(pos_cnt) == Z - 1) begin
          pos_cnt <= '0;
          if (last_bit) begin
            blk_cnt <= '0;
            cp_cnt  <= '0;
            state   <= S_COPY;
          end else begin
            blk_cnt <= blk_cnt + 1'b1;
          end
        end else begin
          pos_cnt <= pos_cnt + 1'b1;
        end
      end
    end else begin
      cp_cnt <= cp_cnt + 1'b1;
      if (wr_commit) state <= S_ENC;
    end
  end

  qc_in_store #(.Z(Z), .KMAX(KMAX), .NBLK(NBLK)) u_in (
    .clk(clk), .we(accept), .wblk(blk_cnt), .wpos(pos_cnt), .wbit(in_bit),
    .rblk(cp_cnt), .rword(in_word));

  for (genvar p = 0; p < NPU; p++) begin : g_unit
    qc_gen_bank #(.Z(Z), .KMAX(KMAX), .NRATE(NRATE), .BANK(p)) u_gen (
      .addr(rom_addr), .vec(rom_vec[p]));
    qc_mac_unit #(.Z(Z)) u_mac (
      .clk(clk), .rst(rst), .en(accept), .load(pos_cnt == '0), .clr(first),
      .din(in_bit), .gvec(rom_vec[p]), .acc(acc[p]));
  end

  always_comb begin
    int kc;
    kc      = int'(kval(cur_m));
    cw_word = '0;
    if (int'(cp_cnt) < kc) cw_word = in_word;
    else
      for (int p = 0; p < NPU; p++)
        if (int'(cp_cnt) == kc + p) cw_word = acc[p];
  end

  qc_out_store #(.Z(Z), .NBLK(NBLK)) u_out (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_blk(cp_cnt), .wr_data(cw_word),
    .wr_commit(wr_commit), .wr_free(wr_free), .out_ready(out_ready),
    .out_valid(out_valid), .out_bit(out_bit), .out_last(out_last));

  // Checker counter: bits accepted since the last commit
  always_ff @(posedge clk) begin
    if (rst || wr_commit) tally <= '0;
    else if (accept)      tally <= tally + 1'b1;
  end

  // R2: each committed codeword consumed exactly k*Z information bits
  assert_commit_len_R2: assert property (@(posedge clk) disable iff (rst)
    wr_commit |-> (int'(tally) == int'(kval(cur_m)) * Z));
endmodule

// File: tb/qc_ldpc_enc_tb.sv
module qc_ldpc_enc_tb;
  localparam int Z    = 8;
  localparam int NBLK = 5;
  localparam int CW   = NBLK * Z;
  localparam int NV   = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] rate_sel = 2'd0;
  logic in_valid = 1'b0, in_bit = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, out_bit, out_last;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  qc_ldpc_enc #(.Z(Z), .NBLK(NBLK)) u_dut (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .in_valid(in_valid),
    .in_bit(in_bit), .in_ready(in_ready), .out_valid(out_valid),
    .out_bit(out_bit), .out_last(out_last), .out_ready(out_ready));

  // Vector fields: [1:0] rate, [3:2] msg kind, [11:4] pos, [12] change,
  // [14:13] new rate, [15] stall, [31:16] seed
  function automatic logic [31:0] mk(int r, int kind, int pos, int chg, int nr, int st, int seed);
    return {16'(seed), 1'(st), 2'(nr), 1'(chg), 8'(pos), 2'(kind), 2'(r)};
  endfunction

  localparam logic [31:0] VEC [NV] = '{
    mk(0, 0, 0, 0, 0, 0, 16'h1234), mk(1, 0, 0, 0, 0, 0, 16'h0BAD),
    mk(2, 0, 0, 0, 0, 0, 16'hC0DE), mk(3, 0, 0, 0, 0, 0, 16'h5A5A),
    mk(0, 2, 5, 0, 0, 0, 1),        mk(1, 2, 13, 0, 0, 0, 1),
    mk(2, 2, 31, 0, 0, 0, 1),       mk(2, 1, 0, 0, 0, 0, 1),
    mk(1, 3, 0, 0, 0, 0, 1),        mk(0, 0, 0, 1, 2, 1, 16'h7777),
    mk(2, 0, 0, 1, 0, 1, 16'h2468), mk(1, 0, 0, 0, 0, 1, 16'h9999)};

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int kref(int r);
    return (r == 1) ? 3 : (r == 2) ? 4 : 2;
  endfunction

  function automatic logic [Z-1:0] gref(int m, int i, int p);
    logic [31:0] x, h;
    x = 32'(16 * m + 4 * i + p + 1) * 32'h9E3779B1;
    h = x ^ (x >> 15);
    return h[Z-1:0];
  endfunction

  function automatic logic [CW-1:0] encode_ref(int m, logic [CW-1:0] u);
    logic [CW-1:0] cw;
    logic [Z-1:0] g;
    int k;
    k = kref(m);
    cw = '0;
    for (int b = 0; b < k * Z; b++) cw[b] = u[b];
    for (int i = 0; i < k; i++)
      for (int r = 0; r < Z; r++)
        if (u[i * Z + r])
          for (int p = 0; p < NBLK - k; p++) begin
            g = gref(m, i, p);
            for (int c = 0; c < Z; c++)
              cw[(k + p) * Z + c] ^= g[(c - r + Z) % Z];
          end
    return cw;
  endfunction

  function automatic logic [CW-1:0] msg_gen(int kind, int pos, logic [15:0] seed);
    logic [CW-1:0] u;
    logic [15:0] s;
    s = (seed == 0) ? 16'hACE1 : seed;
    u = '0;
    for (int b = 0; b < CW; b++) begin
      case (kind)
        0: begin s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]}; u[b] = s[0]; end
        1: u[b] = 1'b1;
        2: u[b] = (b == pos);
        default: u[b] = 1'b0;
      endcase
    end
    return u;
  endfunction

  task automatic send(logic [CW-1:0] u, logic [1:0] r, int nbits, bit chg, logic [1:0] nr);
    int idx;
    idx = 0;
    while (idx < nbits) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_bit   = u[idx];
      rate_sel = (chg && idx >= 1) ? nr : r;
      if (in_ready) idx++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic recv(output logic [CW-1:0] cw, output bit last_ok, input bit stall);
    int idx, cyc;
    idx = 0; cyc = 0; last_ok = 1'b1; cw = '0;
    while (idx < CW) begin
      @(negedge clk);
      cyc++;
      out_ready = stall ? (cyc % 3 != 0) : 1'b1;
      if (out_valid && out_ready) begin
        cw[idx] = out_bit;
        if (out_last != (idx == CW - 1)) last_ok = 1'b0;
        idx++;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [CW-1:0] u, exp, got, ua, ub, ga, gb;
    logic [CW-1:0] imask;
    bit lok;
    logic held;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'd1);

    for (int v = 0; v < NV; v++) begin
      logic [31:0] e;
      int r, m, k;
      string tag;
      e = VEC[v];
      r = int'(e[1:0]);
      m = (r == 3) ? 0 : r;
      k = kref(m);
      u = msg_gen(int'(e[3:2]), int'(e[11:4]), e[31:16]);
      exp = encode_ref(m, u);
      imask = (CW'(1) << (k * Z)) - 1;
      fork
        send(u, 2'(r), k * Z, e[12], e[14:13]);
        recv(got, lok, e[15]);
      join
      tag = e[12] ? "R5" : (r == 3) ? "R2" : "R3";
      check((got & imask) == (exp & imask), tag, $sformatf("info bits vec %0d", v),
            64'(got & imask), 64'(exp & imask));
      check((got & ~imask) == (exp & ~imask), "R4", $sformatf("parity vec %0d", v),
            64'(got & ~imask), 64'(exp & ~imask));
      check(lok, "R7", $sformatf("out_last position vec %0d", v), 64'(lok), 64'd1);
    end

    // R6: two codewords held with output blocked, then drained
    ua = msg_gen(0, 0, 16'h3141);
    ub = msg_gen(0, 0, 16'h2718);
    out_ready = 1'b0;
    send(ua, 2'd2, 4 * Z, 1'b0, 2'd0);
    send(ub, 2'd1, 3 * Z, 1'b0, 2'd0);
    repeat (12) @(negedge clk);
    check(in_ready == 1'b0, "R6", "in_ready with both halves full", 64'(in_ready), 64'd0);
    check(out_valid == 1'b1, "R6", "out_valid with data held", 64'(out_valid), 64'd1);
    held = out_bit;
    repeat (4) @(negedge clk);
    check(out_bit == held && out_valid, "R7", "out_bit held under stall", 64'(out_bit), 64'(held));
    recv(ga, lok, 1'b0);
    check(ga == encode_ref(2, ua), "R6", "first held codeword", 64'(ga), 64'(encode_ref(2, ua)));
    recv(gb, lok, 1'b1);
    check(gb == encode_ref(1, ub), "R6", "second held codeword", 64'(gb), 64'(encode_ref(1, ub)));
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R6", "in_ready after drain", 64'(in_ready), 64'd1);
    check(out_valid == 1'b0, "R6", "out_valid after drain", 64'(out_valid), 64'd0);

    finish_run();
  end
endmodule